// File: doc/BRIEF.md
# Register-Reference Operation Unit

This unit executes the register-reference class of instructions of a 16-bit accumulator machine. The machine also has a one-bit extension flag E. The controller strobes `en_i` for one cycle in the execute phase of such an instruction. It presents the 12-bit operation field and the current accumulator and extension flag.

One cycle later the unit presents the following:
- the updated accumulator and flag;
- a one-cycle skip pulse, which asks the sequencer to advance the program counter once more;
- a one-cycle halt pulse, which clears the run flip-flop;
- a one-cycle request to clear the sequence counter.

Each bit of the operation field selects its own micro-operation. A well-formed instruction sets exactly one bit. If several bits are set, only the most significant one takes effect.

Top module: `rr_exec_unit`

## Requirements
- R1: After reset is asserted, `ac_o` is 0, `e_o` is 0, and `skip_o`, `halt_o` and `sc_clr_o` are all low.
- R2: Clearing. With op bit 11 selected, `ac_o` becomes 0 and E passes through unchanged. With op bit 10 selected, `e_o` becomes 0 and AC passes through unchanged.
- R3: Complementing. Op bit 9 gives `ac_o = ~ac_i`. Op bit 8 gives `e_o = ~e_i`. In each case the other register passes through.
- R4: Rotating through E.
  - Op bit 7 (right) gives `ac_o = {e_i, ac_i[15:1]}` and `e_o = ac_i[0]`.
  - Op bit 6 (left) gives `ac_o = {ac_i[14:0], e_i}` and `e_o = ac_i[15]`.
- R5: Op bit 5 gives `ac_o = ac_i + 1`, wrapping from 16'hFFFF to 0. E is unchanged.
- R6: Conditional skips. `skip_o` pulses in each of these cases, and in no other case:
  - op bit 4 with `ac_i[15]` = 0;
  - op bit 3 with `ac_i[15]` = 1;
  - op bit 2 with `ac_i` = 0;
  - op bit 1 with `e_i` = 0.

  These operations leave AC and E unchanged.
- R7: Op bit 0 pulses `halt_o` and leaves AC and E unchanged.
- R8: Every cycle with `en_i` high produces `sc_clr_o` high in the following cycle. This holds for any operation field, including all zeros.
- R9: When several op bits are set, only the highest-numbered set bit acts. When no bit is set, AC and E pass through and there is no skip and no halt.
- R10: Outputs react one cycle after the enable. In a cycle following one with `en_i` low, `skip_o`, `halt_o` and `sc_clr_o` are low, and `ac_o` and `e_o` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Execute strobe for a register-reference instruction |
| op_i | input | 12 | Operation field, one bit per micro-operation |
| ac_i | input | 16 | Current accumulator |
| e_i | input | 1 | Current extension flag |
| ac_o | output | 16 | Updated accumulator |
| e_o | output | 1 | Updated extension flag |
| skip_o | output | 1 | Skip-next-instruction pulse |
| halt_o | output | 1 | Halt pulse (clears run flag) |
| sc_clr_o | output | 1 | Sequence-counter clear pulse |

## Verification
The assertions are checked on every cycle:
- the priority grant is never more than one-hot;
- a pulse never appears without a preceding enable;
- idle cycles leave the accumulator and flag stable;
- the right rotate and a lone halt bit produce their exact results.

Only the bench's scenarios can show the full value of every operation against independent arithmetic. This covers increment wrap, the skip conditions at the sign and zero boundaries, and the multi-bit priority outcome.

// File: rtl/rr_pkg.sv
package rr_pkg;
  localparam int OP_W   = 12;
  localparam int DATA_W = 16;
  // operation bit positions (priority: higher index wins)
  localparam int B_CLR_AC = 11;
  localparam int B_CLR_E  = 10;
  localparam int B_CPL_AC = 9;
  localparam int B_CPL_E  = 8;
  localparam int B_ROR    = 7;
  localparam int B_ROL    = 6;
  localparam int B_INC    = 5;
  localparam int B_SK_POS = 4;
  localparam int B_SK_NEG = 3;
  localparam int B_SK_ZAC = 2;
  localparam int B_SK_ZE  = 1;
  localparam int B_HALT   = 0;
endpackage

// File: rtl/rr_prio.sv
module rr_prio #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] req_i,
  output logic [W-1:0] gnt_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  // R9
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R9
  gnt_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != '0) |-> (gnt_o != '0));
endmodule

// File: rtl/rr_alu.sv
module rr_alu
  import rr_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [OP_W-1:0] sel_i,
  input  logic [DW-1:0]   ac_i,
  input  logic            e_i,
  output logic [DW-1:0]   ac_o,
  output logic            e_o,
  output logic            skip_o,
  output logic            halt_o
);
  logic ac_zero, ac_neg;
  assign ac_zero = (ac_i == '0);
  assign ac_neg  = ac_i[DW-1];

  always_comb begin
    ac_o   = ac_i;
    e_o    = e_i;
    skip_o = 1'b0;
    halt_o = 1'b0;
    if (sel_i[B_CLR_AC]) ac_o = '0;
    if (sel_i[B_CLR_E])  e_o  = 1'b0;
    if (sel_i[B_CPL_AC]) ac_o = ~ac_i;
    if (sel_i[B_CPL_E])  e_o  = ~e_i;
    if (sel_i[B_ROR]) begin
      ac_o = {e_i, ac_i[DW-1:1]};
      e_o  = ac_i[0];
    end
    if (sel_i[B_ROL]) begin
      ac_o = {ac_i[DW-2:0], e_i};
      e_o  = ac_i[DW-1];
    end
    if (sel_i[B_INC])    ac_o = ac_i + 1'b1;
    if (sel_i[B_SK_POS] && !ac_neg) skip_o = 1'b1;
    if (sel_i[B_SK_NEG] &&  ac_neg) skip_o = 1'b1;
    if (sel_i[B_SK_ZAC] &&  ac_zero) skip_o = 1'b1;
    if (sel_i[B_SK_ZE]  && !e_i)    skip_o = 1'b1;
    if (sel_i[B_HALT])   halt_o = 1'b1;
  end
endmodule

// File: rtl/rr_exec_unit.sv
module rr_exec_unit
  import rr_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [DW-1:0]   ac_i,
  input  logic            e_i,
  output logic [DW-1:0]   ac_o,
  output logic            e_o,
  output logic            skip_o,
  output logic            halt_o,
  output logic            sc_clr_o
);
  logic [OP_W-1:0] sel;
  logic [DW-1:0]   ac_n;
  logic            e_n, skip_n, halt_n;

  rr_prio #(.W(OP_W)) u_prio (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (op_i),
    .gnt_o (sel)
  );

  rr_alu #(.DW(DW)) u_alu (
    .sel_i (sel),
    .ac_i  (ac_i),
    .e_i   (e_i),
    .ac_o  (ac_n),
    .e_o   (e_n),
    .skip_o(skip_n),
    .halt_o(halt_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_o     <= '0;
      e_o      <= 1'b0;
      skip_o   <= 1'b0;
      halt_o   <= 1'b0;
      sc_clr_o <= 1'b0;
    end else begin
      skip_o   <= en_i & skip_n;
      halt_o   <= en_i & halt_n;
      sc_clr_o <= en_i;
      if (en_i) begin
        ac_o <= ac_n;
        e_o  <= e_n;
      end
    end
  end

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(ac_o) && $stable(e_o) && !skip_o && !halt_o));
  // R8
  pulse_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (skip_o || halt_o) |-> sc_clr_o);
  // R7
  halt_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 12'h001) |=> (halt_o && !skip_o && ac_o == $past(ac_i)));
  // R4
  ror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == 12'h080) |=>
      (ac_o == {$past(e_i), $past(ac_i[DW-1:1])} && e_o == $past(ac_i[0])));
  // R9
  skip_halt_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(skip_o && halt_o));
endmodule

// File: tb/rr_exec_unit_bench.sv
module rr_exec_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [11:0] op_i = '0;
  logic [15:0] ac_i = '0;
  logic        e_i = 1'b0;
  logic [15:0] ac_o;
  logic        e_o, skip_o, halt_o, sc_clr_o;

  int n_run = 0, n_fail = 0;
  logic [15:0] last_ac;
  logic        last_e;

  always #10 clk_i = ~clk_i;

  rr_exec_unit u_rr_exec_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .op_i(op_i),
    .ac_i(ac_i), .e_i(e_i), .ac_o(ac_o), .e_o(e_o),
    .skip_o(skip_o), .halt_o(halt_o), .sc_clr_o(sc_clr_o)
  );

  function automatic int top_bit(input logic [11:0] op);
    for (int i = 11; i >= 0; i--) if (op[i]) return i;
    return -1;
  endfunction

  function automatic logic [18:0] model(input logic [11:0] op,
                                        input logic [15:0] a, input logic e);
    logic [15:0] na; logic ne, sk, ht;
    na = a; ne = e; sk = 0; ht = 0;
    case (top_bit(op))
      11: na = 16'h0;
      10: ne = 1'b0;
      9:  na = ~a;
      8:  ne = ~e;
      7:  begin na = {e, a[15:1]}; ne = a[0]; end
      6:  begin na = {a[14:0], e}; ne = a[15]; end
      5:  na = a + 16'd1;
      4:  sk = !a[15];
      3:  sk = a[15];
      2:  sk = (a == 16'h0);
      1:  sk = !e;
      0:  ht = 1'b1;
      default: ;
    endcase
    return {na, ne, sk, ht};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [11:0] op,
                        input logic [15:0] a, input logic e);
    logic [18:0] m;
    m = model(op, a, e);
    @(negedge clk_i);
    en_i = 1'b1; op_i = op; ac_i = a; e_i = e;
    @(negedge clk_i);
    en_i = 1'b0;
    chk(req, {ac_o, e_o, skip_o, halt_o, sc_clr_o}, {m, 1'b1});
    last_ac = m[18:3]; last_e = m[2];
  endtask

  task automatic idle(input string req);
    @(negedge clk_i);
    op_i = $urandom; ac_i = $urandom; e_i = $urandom;
    @(negedge clk_i);
    chk(req, {ac_o, e_o, skip_o, halt_o, sc_clr_o}, {last_ac, last_e, 3'b000});
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7041));
    repeat (3) @(negedge clk_i);
    chk("R1 reset", {ac_o, e_o, skip_o, halt_o, sc_clr_o}, 21'h0);
    rst_ni = 1'b1;
    // directed corners
    run_op("R2 clr_ac", 12'h800, 16'hBEEF, 1'b1);
    run_op("R2 clr_e",  12'h400, 16'h1234, 1'b1);
    run_op("R3 cpl_ac", 12'h200, 16'h00F0, 1'b0);
    run_op("R3 cpl_e",  12'h100, 16'h5555, 1'b0);
    run_op("R4 ror",    12'h080, 16'h8001, 1'b0);
    run_op("R4 rol",    12'h040, 16'h8001, 1'b1);
    run_op("R5 inc_wrap", 12'h020, 16'hFFFF, 1'b1);
    run_op("R6 spa_pos",  12'h010, 16'h7FFF, 1'b0);
    run_op("R6 spa_neg",  12'h010, 16'h8000, 1'b0);
    run_op("R6 sna_neg",  12'h008, 16'h8000, 1'b0);
    run_op("R6 sna_zero", 12'h008, 16'h0000, 1'b0);
    run_op("R6 sza_zero", 12'h004, 16'h0000, 1'b1);
    run_op("R6 sza_one",  12'h004, 16'h0001, 1'b1);
    run_op("R6 sze_0",    12'h002, 16'h1111, 1'b0);
    run_op("R6 sze_1",    12'h002, 16'h1111, 1'b1);
    run_op("R7 halt",     12'h001, 16'hCAFE, 1'b1);
    run_op("R8 zero_op",  12'h000, 16'h4321, 1'b1);
    run_op("R9 prio_cpl_over_inc", 12'h220, 16'h0F0F, 1'b0);
    run_op("R9 prio_skip_over_halt", 12'h005, 16'h0000, 1'b0);
    idle("R10 idle");
    // random: mostly one-hot, some multi-hot
    for (int k = 0; k < 400; k++) begin
      logic [11:0] op;
      if (k % 4 == 3) op = 12'($urandom);
      else            op = 12'h1 << ($urandom % 12);
      run_op("R9 random", op, 16'($urandom), 1'($urandom));
      if (k % 16 == 0) idle("R10 random_idle");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule